// File: doc/BRIEF.md
# PLL Divider and Band Selector

This block turns a requested lane bit clock and a reference clock into a complete divider setting for a PHY PLL. Both frequencies are unsigned integers in MHz. A pulse on `start` captures them. The block first looks up the frequency band for the requested clock. It then walks every allowed input predivider, from lowest to highest, using one shared bit-serial divider. It keeps the predivider whose product with the lane clock leaves the smallest remainder against the reference. A final pass through the same divider works out the lane clock that the chosen setting actually produces.

The results are presented on the output pins, together with the bytes a configuration sequencer writes into the PHY: the VCO range byte, the band byte, the predivider byte and the two feedback-divider bytes. The block raises `done` for one cycle when the results are ready, and the results then hold until the next job finishes. `start` and `done` are plain control pins. The block has no data stream and no back-pressure, so the block accepts no new job until `busy` is low.

Top module: `pll_div_sel`

## Requirements
- R1: The candidate predividers are every integer from `ref/40 + 1` up to, but not including, `ref/5`, where both divisions round down. They are tried in ascending order.
- R2: A candidate c is accepted only when both of these hold. First, `(lane*c) mod ref` is strictly smaller than the best remainder so far. Second, `(lane*c)/ref` is below the parameter FB_LIMIT. The best remainder starts at all ones, and on a tie the earlier (smaller) candidate is kept. `prediv` is the last accepted candidate.
- R3: `fbdiv` equals `(lane*prediv)/ref`, and `actual_mhz` equals `(ref*fbdiv)/prediv`, both rounded down.
- R4: `err_ref` is set, and every numeric output is 0, in either of two cases: `ref/5 < ref/40 + 1`, or no candidate is accepted (which includes an empty candidate range). `err_ref` and `err_band` are never set together.
- R5: The band code is taken from the first entry of an ascending threshold table whose threshold is at least `lane`, and `band_byte` is that code shifted left by one. The table entries, written as threshold:code (code in hex), are 90:01 100:10 110:20 130:01 140:11 150:21 170:02 180:12 200:22 220:03 240:13 250:23 270:04 300:14 330:05 360:15 400:25 450:06 500:16 550:07 600:17 650:08 700:18 750:09 800:19 850:29 900:39 950:0a 1000:1a 1050:2a 1100:3a 1150:0b 1200:1b 1250:2b 1300:3b 1350:0c 1400:1c 1450:2c 1500:3c.
- R6: When `lane` is above 1500, `err_band` is set and every numeric output is 0. This check is made before the reference check of R4.
- R7: `vco_byte` is `0x80 | ((lane/200) << 3) | 0x03`, truncated to 8 bits.
- R8: `prediv_byte` is `prediv-1`. With f = `fbdiv-1`, `fb_lo_byte` holds bits 4:0 of f in its low bits and zeros above them. `fb_hi_byte` is `0x80 | (f >> 5)`.
- R9: `start` is only sampled while `busy` is low, and the inputs are captured in that cycle. `busy` stays high from the next cycle up to and including the single cycle in which `done` is high. A `start` pulse, or any change on the inputs, while `busy` is high has no effect.
- R10: The results stay unchanged from one `done` to the next. After reset, `busy`, `done`, both error flags and every numeric output are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Job request, sampled while idle |
| lane_mhz | input | FW | Requested lane bit clock, MHz |
| ref_mhz | input | FW | Reference clock, MHz |
| busy | output | 1 | A job is in progress |
| done | output | 1 | One-cycle pulse when the results are ready |
| err_ref | output | 1 | No usable predivider for this reference |
| err_band | output | 1 | Lane clock is above the top band |
| prediv | output | FW | Chosen input predivider |
| fbdiv | output | FBW | Chosen feedback divider |
| actual_mhz | output | FW | Lane clock that the chosen dividers produce |
| vco_byte | output | 8 | VCO range configuration byte |
| band_byte | output | 8 | Band code shifted left by one |
| prediv_byte | output | 8 | Predivider minus one |
| fb_lo_byte | output | 8 | Low five bits of feedback minus one |
| fb_hi_byte | output | 8 | Upper bits of feedback minus one, with bit 7 set |

## Verification
The bench builds the block with FW=12 and reduces FB_LIMIT to 100. At that limit, ordinary lane and reference pairs produce quotients at or above the limit, so the candidate-rejection rule of R2 is exercised. It also allows a lane of 1500 MHz against a 10 MHz reference to reject every candidate and end in `err_ref`. With 12-bit frequencies, the top band edges at 1500 and 1501 MHz and the empty and inverted predivider ranges (5 MHz and 4 MHz references) all fall within range.

// File: rtl/pll_div_pkg.sv
package pll_div_pkg;

  localparam int BAND_N = 39;

  localparam int unsigned BAND_THR [BAND_N] = '{
      90,  100,  110,  130,  140,  150,  170,  180,  200,  220,
     240,  250,  270,  300,  330,  360,  400,  450,  500,  550,
     600,  650,  700,  750,  800,  850,  900,  950, 1000, 1050,
    1100, 1150, 1200, 1250, 1300, 1350, 1400, 1450, 1500};

  localparam logic [5:0] BAND_CODE [BAND_N] = '{
    6'h01, 6'h10, 6'h20, 6'h01, 6'h11, 6'h21, 6'h02, 6'h12, 6'h22, 6'h03,
    6'h13, 6'h23, 6'h04, 6'h14, 6'h05, 6'h15, 6'h25, 6'h06, 6'h16, 6'h07,
    6'h17, 6'h08, 6'h18, 6'h09, 6'h19, 6'h29, 6'h39, 6'h0a, 6'h1a, 6'h2a,
    6'h3a, 6'h0b, 6'h1b, 6'h2b, 6'h3b, 6'h0c, 6'h1c, 6'h2c, 6'h3c};

  typedef enum logic [2:0] {
    ST_IDLE, ST_CHECK, ST_LOAD, ST_WAIT, ST_FINAL, ST_FWAIT, ST_DONE
  } sel_state_t;

endpackage

// File: rtl/pll_band_lut.sv
module pll_band_lut
  import pll_div_pkg::*;
#(
  parameter int FW = 12
) (
  input  logic [FW-1:0] lane_mhz,
  output logic          hit,
  output logic [5:0]    code
);

  // Scan from the top entry down, so that the lowest matching threshold is
  // the one left in place.
  always_comb begin
    hit  = 1'b0;
    code = '0;
    for (int i = BAND_N - 1; i >= 0; i--) begin
      if (32'(lane_mhz) <= BAND_THR[i]) begin
        hit  = 1'b1;
        code = BAND_CODE[i];
      end
    end
  end

endmodule

// File: rtl/pll_seq_div.sv
module pll_seq_div #(
  parameter int NW = 24,
  parameter int DW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          go,
  input  logic [NW-1:0] num,
  input  logic [DW-1:0] den,
  output logic          fin,
  output logic [NW-1:0] quo,
  output logic [DW-1:0] rem
);

  localparam int CW = $clog2(NW + 1);

  logic [NW-1:0] sh_q;
  logic [DW-1:0] rem_q;
  logic [DW-1:0] den_q;
  logic [CW-1:0] cnt_q;
  logic          fin_q;
  logic [DW:0]   trial;

  assign trial = {rem_q, sh_q[NW-1]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q  <= '0;
      rem_q <= '0;
      den_q <= '0;
      cnt_q <= '0;
      fin_q <= 1'b0;
    end else begin
      fin_q <= 1'b0;
      if (go) begin
        sh_q  <= num;
        rem_q <= '0;
        den_q <= den;
        cnt_q <= CW'(NW);
      end else if (cnt_q != '0) begin
        if (trial >= {1'b0, den_q}) begin
          rem_q <= DW'(trial - {1'b0, den_q});
          sh_q  <= {sh_q[NW-2:0], 1'b1};
        end else begin
          rem_q <= trial[DW-1:0];
          sh_q  <= {sh_q[NW-2:0], 1'b0};
        end
        cnt_q <= cnt_q - 1'b1;
        if (cnt_q == CW'(1)) fin_q <= 1'b1;
      end
    end
  end

  assign fin = fin_q;
  assign quo = sh_q;
  assign rem = rem_q;

  // R3: a finished division always leaves a remainder below the divisor
  p_rem_below_den_r3: assert property (@(posedge clk) disable iff (!rst_n)
    fin |-> (rem_q < den_q));

endmodule

// File: rtl/pll_div_sel.sv
module pll_div_sel
  import pll_div_pkg::*;
#(
  parameter int FW          = 12,
  parameter int FB_LIMIT    = 1000,
  parameter int CMP_MIN_MHZ = 5,
  parameter int CMP_MAX_MHZ = 40,
  parameter int FBW         = $clog2(FB_LIMIT)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic [FW-1:0]  lane_mhz,
  input  logic [FW-1:0]  ref_mhz,
  output logic           busy,
  output logic           done,
  output logic           err_ref,
  output logic           err_band,
  output logic [FW-1:0]  prediv,
  output logic [FBW-1:0] fbdiv,
  output logic [FW-1:0]  actual_mhz,
  output logic [7:0]     vco_byte,
  output logic [7:0]     band_byte,
  output logic [7:0]     prediv_byte,
  output logic [7:0]     fb_lo_byte,
  output logic [7:0]     fb_hi_byte
);

  localparam int PW = 2 * FW;

  sel_state_t    st_q;
  logic [FW-1:0] lane_q, ref_q;
  logic [FW-1:0] cand_q, cand_end_q;
  logic [FW-1:0] best_rem_q, best_pre_q;
  logic [FBW-1:0] best_fb_q;
  logic          found_q;
  logic [5:0]    band_code_q;

  logic          band_hit;
  logic [5:0]    band_code;
  logic [FW-1:0] lo_c, hi_c;
  logic          div_go, div_fin;
  logic [PW-1:0] div_num, div_quo;
  logic [FW-1:0] div_den, div_rem;
  logic [15:0]   fbm1;
  logic [7:0]    vco_c;

  pll_band_lut #(.FW(FW)) band_i (
    .lane_mhz (lane_q),
    .hit      (band_hit),
    .code     (band_code)
  );

  assign lo_c = FW'(ref_q / FW'(CMP_MAX_MHZ)) + FW'(1);
  assign hi_c = FW'(ref_q / FW'(CMP_MIN_MHZ));

  // One divider serves both the candidate search and the final clock pass
  assign div_go  = ((st_q == ST_LOAD) && (cand_q < cand_end_q)) ||
                   (st_q == ST_FINAL);
  assign div_num = (st_q == ST_FINAL) ? PW'(ref_q) * PW'(best_fb_q)
                                      : PW'(lane_q) * PW'(cand_q);
  assign div_den = (st_q == ST_FINAL) ? best_pre_q : ref_q;

  pll_seq_div #(.NW(PW), .DW(FW)) div_i (
    .clk   (clk),
    .rst_n (rst_n),
    .go    (div_go),
    .num   (div_num),
    .den   (div_den),
    .fin   (div_fin),
    .quo   (div_quo),
    .rem   (div_rem)
  );

  assign fbm1  = 16'(best_fb_q) - 16'd1;
  assign vco_c = 8'h80 | 8'(32'(lane_q / FW'(200)) << 3) | 8'h03;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q        <= ST_IDLE;
      lane_q      <= '0;
      ref_q       <= '0;
      cand_q      <= '0;
      cand_end_q  <= '0;
      best_rem_q  <= '1;
      best_pre_q  <= '0;
      best_fb_q   <= '0;
      found_q     <= 1'b0;
      band_code_q <= '0;
      err_ref     <= 1'b0;
      err_band    <= 1'b0;
      prediv      <= '0;
      fbdiv       <= '0;
      actual_mhz  <= '0;
      vco_byte    <= '0;
      band_byte   <= '0;
      prediv_byte <= '0;
      fb_lo_byte  <= '0;
      fb_hi_byte  <= '0;
    end else begin
      case (st_q)
        ST_IDLE: begin
          if (start) begin
            lane_q <= lane_mhz;
            ref_q  <= ref_mhz;
            st_q   <= ST_CHECK;
          end
        end
        ST_CHECK: begin
          band_code_q <= band_code;
          best_rem_q  <= '1;
          found_q     <= 1'b0;
          cand_q      <= lo_c;
          cand_end_q  <= hi_c;
          if (!band_hit || (hi_c < lo_c)) begin
            err_band    <= !band_hit;
            err_ref     <= band_hit;
            prediv      <= '0;
            fbdiv       <= '0;
            actual_mhz  <= '0;
            vco_byte    <= '0;
            band_byte   <= '0;
            prediv_byte <= '0;
            fb_lo_byte  <= '0;
            fb_hi_byte  <= '0;
            st_q        <= ST_DONE;
          end else begin
            st_q <= ST_LOAD;
          end
        end
        ST_LOAD: begin
          if (cand_q < cand_end_q) begin
            st_q <= ST_WAIT;
          end else if (found_q) begin
            st_q <= ST_FINAL;
          end else begin
            err_band    <= 1'b0;
            err_ref     <= 1'b1;
            prediv      <= '0;
            fbdiv       <= '0;
            actual_mhz  <= '0;
            vco_byte    <= '0;
            band_byte   <= '0;
            prediv_byte <= '0;
            fb_lo_byte  <= '0;
            fb_hi_byte  <= '0;
            st_q        <= ST_DONE;
          end
        end
        ST_WAIT: begin
          if (div_fin) begin
            if ((div_rem < best_rem_q) && (div_quo < PW'(FB_LIMIT))) begin
              best_rem_q <= div_rem;
              best_pre_q <= cand_q;
              best_fb_q  <= FBW'(div_quo);
              found_q    <= 1'b1;
            end
            cand_q <= cand_q + FW'(1);
            st_q   <= ST_LOAD;
          end
        end
        ST_FINAL: st_q <= ST_FWAIT;
        ST_FWAIT: begin
          if (div_fin) begin
            err_ref     <= 1'b0;
            err_band    <= 1'b0;
            prediv      <= best_pre_q;
            fbdiv       <= best_fb_q;
            actual_mhz  <= FW'(div_quo);
            vco_byte    <= vco_c;
            band_byte   <= {1'b0, band_code_q, 1'b0};
            prediv_byte <= 8'(best_pre_q - FW'(1));
            fb_lo_byte  <= {3'b000, fbm1[4:0]};
            fb_hi_byte  <= 8'h80 | 8'(fbm1 >> 5);
            st_q        <= ST_DONE;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign busy = (st_q != ST_IDLE);
  assign done = (st_q == ST_DONE);

  // R9: done is a single-cycle pulse
  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R10: results do not move while the block is idle
  p_hold_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy) |=> $stable({prediv, fbdiv, actual_mhz, err_ref, err_band}));

  // R4: the two error causes exclude each other
  p_err_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(err_ref && err_band));

  // R2: a successful result respects the feedback limit and a nonzero predivider
  p_fb_in_limit_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !err_ref && !err_band) |-> ((32'(fbdiv) < FB_LIMIT) && (prediv != '0)));

  // R2: the best remainder never grows while the search is running
  p_best_shrinks_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_WAIT) |=> (best_rem_q <= $past(best_rem_q)));

endmodule

// File: tb/pll_div_sel_tb_top.sv
module pll_div_sel_tb_top;

  localparam int FW  = 12;
  localparam int FBL = 100;
  localparam int FBW = $clog2(FBL);

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           start = 1'b0;
  logic [FW-1:0]  lane_mhz = '0;
  logic [FW-1:0]  ref_mhz = '0;
  logic           busy, done, err_ref, err_band;
  logic [FW-1:0]  prediv, actual_mhz;
  logic [FBW-1:0] fbdiv;
  logic [7:0]     vco_byte, band_byte, prediv_byte, fb_lo_byte, fb_hi_byte;

  int n_chk = 0;
  int n_bad = 0;

  int e_pre = 0, e_fb = 0, e_act = 0, e_vco = 0, e_band = 0;
  int e_pb = 0, e_flo = 0, e_fhi = 0, e_er = 0, e_eb = 0;

  int thr  [39] = '{90, 100, 110, 130, 140, 150, 170, 180, 200, 220, 240, 250,
                    270, 300, 330, 360, 400, 450, 500, 550, 600, 650, 700, 750,
                    800, 850, 900, 950, 1000, 1050, 1100, 1150, 1200, 1250,
                    1300, 1350, 1400, 1450, 1500};
  int bcode[39] = '{'h01, 'h10, 'h20, 'h01, 'h11, 'h21, 'h02, 'h12, 'h22, 'h03,
                    'h13, 'h23, 'h04, 'h14, 'h05, 'h15, 'h25, 'h06, 'h16, 'h07,
                    'h17, 'h08, 'h18, 'h09, 'h19, 'h29, 'h39, 'h0a, 'h1a, 'h2a,
                    'h3a, 'h0b, 'h1b, 'h2b, 'h3b, 'h0c, 'h1c, 'h2c, 'h3c};

  always #4 clk = ~clk;

  pll_div_sel #(.FW(FW), .FB_LIMIT(FBL)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start),
    .lane_mhz(lane_mhz), .ref_mhz(ref_mhz),
    .busy(busy), .done(done), .err_ref(err_ref), .err_band(err_band),
    .prediv(prediv), .fbdiv(fbdiv), .actual_mhz(actual_mhz),
    .vco_byte(vco_byte), .band_byte(band_byte), .prediv_byte(prediv_byte),
    .fb_lo_byte(fb_lo_byte), .fb_hi_byte(fb_hi_byte)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Behavioural model of the requirements
  task automatic model(input int lane, input int rf);
    int lo, hi, best, found, code, hitb;
    e_pre = 0; e_fb = 0; e_act = 0; e_vco = 0; e_band = 0;
    e_pb = 0; e_flo = 0; e_fhi = 0; e_er = 0; e_eb = 0;
    hitb = 0; code = 0;
    for (int i = 0; i < 39; i++)
      if (hitb == 0 && lane <= thr[i]) begin hitb = 1; code = bcode[i]; end
    if (hitb == 0) begin e_eb = 1; return; end
    lo = rf / 40 + 1;
    hi = rf / 5;
    best = (1 << FW) - 1;
    found = 0;
    for (int c = lo; c < hi; c++) begin
      if ((lane * c) % rf < best && (lane * c) / rf < FBL) begin
        best = (lane * c) % rf; e_pre = c; e_fb = (lane * c) / rf; found = 1;
      end
    end
    if (found == 0) begin e_er = 1; e_pre = 0; e_fb = 0; return; end
    e_act  = rf * e_fb / e_pre;
    e_vco  = (8'h80 | ((lane / 200) << 3) | 3) & 255;
    e_band = (code << 1) & 255;
    e_pb   = (e_pre - 1) & 255;
    e_flo  = (e_fb - 1) & 31;
    e_fhi  = (8'h80 | ((e_fb - 1) >> 5)) & 255;
  endtask

  task automatic compare_all();
    chk("R2 prediv", int'(prediv), e_pre);
    chk("R3 fbdiv", int'(fbdiv), e_fb);
    chk("R3 actual", int'(actual_mhz), e_act);
    chk("R4 err_ref", int'(err_ref), e_er);
    chk("R6 err_band", int'(err_band), e_eb);
    chk("R5 band_byte", int'(band_byte), e_band);
    chk("R7 vco_byte", int'(vco_byte), e_vco);
    chk("R8 prediv_byte", int'(prediv_byte), e_pb);
    chk("R8 fb_lo_byte", int'(fb_lo_byte), e_flo);
    chk("R8 fb_hi_byte", int'(fb_hi_byte), e_fhi);
  endtask

  task automatic wait_done();
    int w = 0;
    while (!done && w < 40000) begin @(negedge clk); w++; end
    if (!done) chk("R9 watchdog", 0, 1);
  endtask

  task automatic run_job(input int lane, input int rf);
    @(negedge clk);
    lane_mhz = FW'(lane); ref_mhz = FW'(rf); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R9 busy after start", int'(busy), 1);
    wait_done();
    model(lane, rf);
    compare_all();
  endtask

  // Held results are compared on every idle clock
  bit have_res = 0;
  always @(negedge clk) begin
    if (rst_n && have_res && !busy) begin
      chk("R10 held prediv", int'(prediv), e_pre);
      chk("R10 held err", int'({err_ref, err_band}), (e_er << 1) | e_eb);
    end
  end

  initial begin
    #(8 * 150000);
    chk("R9 global watchdog", 0, 1);
    $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10: reset state
    chk("R10 reset busy", int'(busy), 0);
    chk("R10 reset done", int'(done), 0);
    chk("R10 reset prediv", int'(prediv), 0);
    chk("R10 reset err", int'({err_ref, err_band}), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    run_job(1000, 24); have_res = 1;   // R2: third candidate hits the limit
    run_job(480, 24);                  // R2: all remainders zero, tie keeps 1
    run_job(1500, 10);                 // R4: every candidate rejected
    run_job(1000, 4);                  // R4: inverted range
    run_job(1000, 5);                  // R1: empty range, lo == hi
    run_job(1501, 24);                 // R6: above the top band
    run_job(1500, 24);                 // R5: top band edge
    run_job(90, 24);                   // R5: bottom band edge
    run_job(91, 24);                   // R5: just above an edge
    run_job(800, 200);                 // R1: range 6..39
    run_job(1234, 27);
    run_job(333, 19);

    // R9: start and input changes during a job have no effect
    @(negedge clk);
    lane_mhz = FW'(700); ref_mhz = FW'(38); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (5) @(negedge clk);
    chk("R9 busy mid job", int'(busy), 1);
    lane_mhz = FW'(1400); ref_mhz = FW'(100); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wait_done();
    model(700, 38);
    compare_all();
    @(negedge clk);
    chk("R9 done single cycle", int'(done), 0);
    chk("R9 no restart", int'(busy), 0);
    repeat (3) @(negedge clk);

    $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule